// File: doc/BRIEF.md
# Hall Index Divider with Burst Resynchronization

This block turns a spindle Hall sensor signal into one index pulse per disk revolution. The Hall signal completes two cycles per revolution, so the block toggles a flip-flop on each qualified rising Hall edge. That gives a level, `hall_div`, with one cycle per revolution. A single-clock `index_pulse` marks each rising edge of that level.

After power-up the phase of the divide-by-two is arbitrary. To make it repeatable, the block watches a discriminated read-data level while the heads sit on the reference track. The discriminator output stays high during the steady 1.75 MHz tone and drops low during a burst at twice that frequency, which lasts about 4 ms. When the low run has the expected length, the block forces the divider flip-flop to zero and raises `synced`. `synced` stays set until the heads move off the reference track.

All timing windows are parameters expressed in clock cycles. For a 50 MHz clock the defaults give 3.5 ms to 4.5 ms.

Top module: `hall_index_resync`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `index_pulse`, `hall_div` and `synced` are 0.
- R2: `hall_in` passes a two-flip-flop synchronizer. A new level is accepted only after the synchronized level has differed from the accepted level for `DEB_LEN` consecutive cycles. A pulse `DEB_LEN` cycles wide is accepted; a pulse `DEB_LEN-1` cycles wide or shorter has no effect on `hall_div`.
- R3: Each accepted rising Hall edge toggles `hall_div`. Accepted falling edges leave `hall_div` unchanged.
- R4: `index_pulse` is high for exactly one clock cycle each time `hall_div` changes from 0 to 1, and at no other time.
- R5: While `on_ref` is high, a low run of `rd_qual` lasting L cycles, with `LOW_MIN` <= L <= `LOW_MAX`, is accepted as a burst when `rd_qual` returns high.
- R6: A low run shorter than `LOW_MIN` or longer than `LOW_MAX` is not a burst and changes neither `hall_div` nor `synced`.
- R7: An accepted burst clears `hall_div` to 0 within a few cycles. The next accepted rising Hall edge then sets `hall_div` and produces an `index_pulse`.
- R8: `synced` rises after an accepted burst and stays high until `on_ref` goes from 1 to 0; it is 0 in the cycle after that fall.
- R9: While `on_ref` is low, low runs of `rd_qual` of any length have no effect on `hall_div` or `synced`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 1 | Raw Hall sensor level, two cycles per revolution |
| rd_qual | input | 1 | Discriminated read-data level: high on the tone, low during the double-frequency burst |
| on_ref | input | 1 | High while the heads are on the reference track |
| index_pulse | output | 1 | One-clock pulse once per revolution |
| hall_div | output | 1 | Hall level divided by two |
| synced | output | 1 | Divider phase has been aligned since the reference track was entered |

## Verification
Several properties are checked on every cycle by the assertions. The index pulse is one cycle wide and coincides with a fresh rise of the divided level. An accepted burst is followed by a cleared divider and a raised `synced`. Leaving the reference track drops `synced`, and no burst is accepted off the reference track. Other behaviour can only be shown by the bench scenarios. These are the exact debounce boundary at `DEB_LEN` cycles, the inclusive burst window swept cycle by cycle across both limits, the insensitivity to falling Hall edges, and the index phase after a resync.

// File: rtl/hir_pkg.sv
package hir_pkg;
  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/hir_hall_cond.sv
module hir_hall_cond #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hall_in,
  output logic hall_rise
);
  import hir_pkg::*;
  localparam int DW = cnt_bits(DEB_LEN);

  logic          s1, s2, stb, stb_d;
  logic [DW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      stb <= 1'b0;
      stb_d <= 1'b0;
      run <= '0;
    end else begin
      s1 <= hall_in;
      s2 <= s1;
      stb_d <= stb;
      if (s2 == stb) begin
        run <= '0;
      end else if (run == DW'(DEB_LEN - 1)) begin
        stb <= s2;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign hall_rise = stb & ~stb_d;

  // R2
  stb_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |-> $past(s2));
endmodule

// File: rtl/hir_burst_det.sv
module hir_burst_det #(
  parameter int LOW_MIN = 175000,
  parameter int LOW_MAX = 225000
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_qual,
  input  logic on_ref,
  output logic hit
);
  import hir_pkg::*;
  localparam int CW = cnt_bits(LOW_MAX + 1);

  logic          r1, r2;
  logic [CW-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b1;
      r2 <= 1'b1;
      low_len <= '0;
      hit <= 1'b0;
    end else begin
      r1 <= rd_qual;
      r2 <= r1;
      if (!on_ref) begin
        low_len <= '0;
        hit <= 1'b0;
      end else if (!r2) begin
        if (low_len <= CW'(LOW_MAX)) low_len <= low_len + 1'b1;
        hit <= 1'b0;
      end else begin
        hit <= (low_len >= CW'(LOW_MIN)) && (low_len <= CW'(LOW_MAX));
        low_len <= '0;
      end
    end
  end

  // R9
  hit_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(on_ref));
  // R5
  hit_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(r2));
  // R6
  hit_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/hir_divider.sv
module hir_divider (
  input  logic clk,
  input  logic rst,
  input  logic hall_rise,
  input  logic resync,
  output logic div,
  output logic idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div <= 1'b0;
      idx <= 1'b0;
    end else if (resync) begin
      div <= 1'b0;
      idx <= 1'b0;
    end else if (hall_rise) begin
      div <= ~div;
      idx <= ~div;
    end else begin
      idx <= 1'b0;
    end
  end

  // R4
  idx_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
    idx |=> !idx);
  // R4
  idx_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    idx |-> (div && !$past(div)));
  // R7
  resync_clears_chk: assert property (@(posedge clk) disable iff (rst)
    resync |=> !div);
endmodule

// File: rtl/hall_index_resync.sv
module hall_index_resync #(
  parameter int DEB_LEN = 16,
  parameter int LOW_MIN = 175000,
  parameter int LOW_MAX = 225000
) (
  input  logic clk,
  input  logic rst,
  input  logic hall_in,
  input  logic rd_qual,
  input  logic on_ref,
  output logic index_pulse,
  output logic hall_div,
  output logic synced
);
  logic hall_rise, hit, ref_d, sync_q;

  hir_hall_cond #(.DEB_LEN(DEB_LEN)) u_hall (
    .clk(clk), .rst(rst), .hall_in(hall_in), .hall_rise(hall_rise));

  hir_burst_det #(.LOW_MIN(LOW_MIN), .LOW_MAX(LOW_MAX)) u_burst (
    .clk(clk), .rst(rst), .rd_qual(rd_qual), .on_ref(on_ref), .hit(hit));

  hir_divider u_div (
    .clk(clk), .rst(rst), .hall_rise(hall_rise), .resync(hit),
    .div(hall_div), .idx(index_pulse));

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      ref_d <= on_ref;
      if (hit) sync_q <= 1'b1;
      else if (ref_d && !on_ref) sync_q <= 1'b0;
    end
  end

  assign synced = sync_q;

  // R8
  sync_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> synced);
  // R8
  sync_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_d && !on_ref) |=> !synced);
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!index_pulse && !hall_div && !synced));
endmodule

// File: tb/hall_index_resync_test.sv
`timescale 1ns/100ps
module hall_index_resync_test;
  localparam int DEB = 3;
  localparam int LMIN = 20;
  localparam int LMAX = 30;

  logic clk = 1'b0, rst = 1'b1, hall_in = 1'b0, rd_qual = 1'b1, on_ref = 1'b0;
  logic index_pulse, hall_div, synced;
  int total = 0, bad = 0;
  int idx_cnt = 0, idx_run = 0, idx_maxw = 0;
  bit exp_div = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  hall_index_resync #(.DEB_LEN(DEB), .LOW_MIN(LMIN), .LOW_MAX(LMAX)) uut (
    .clk(clk), .rst(rst), .hall_in(hall_in), .rd_qual(rd_qual), .on_ref(on_ref),
    .index_pulse(index_pulse), .hall_div(hall_div), .synced(synced));

  always @(negedge clk) begin
    if (index_pulse) begin
      if (idx_run == 0) idx_cnt++;
      idx_run++;
      if (idx_run > idx_maxw) idx_maxw = idx_run;
    end else idx_run = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hall_cycle(input string req);
    int c0;
    c0 = idx_cnt;
    hall_in = 1'b1; idle(12);
    exp_div = ~exp_div;
    chk(hall_div == exp_div, req, hall_div, exp_div);
    chk(idx_cnt == c0 + (exp_div ? 1 : 0), "R4", idx_cnt, c0 + (exp_div ? 1 : 0));
    hall_in = 1'b0; idle(12);
    chk(hall_div == exp_div, "R3", hall_div, exp_div);
  endtask

  task automatic burst(input int n);
    rd_qual = 1'b0; idle(n);
    rd_qual = 1'b1; idle(8);
  endtask

  initial begin
    idle(4);
    chk(index_pulse == 1'b0, "R1", index_pulse, 0);
    chk(hall_div == 1'b0, "R1", hall_div, 0);
    chk(synced == 1'b0, "R1", synced, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(hall_div == 1'b0 && synced == 1'b0, "R1", hall_div, 0);

    for (int i = 0; i < 6; i++) hall_cycle("R3");

    // R2: glitch widths below DEB rejected, width DEB accepted
    for (int w = 1; w <= DEB; w++) begin
      hall_in = 1'b1; idle(w);
      hall_in = 1'b0; idle(12);
      if (w == DEB) begin
        exp_div = ~exp_div; idle(0);
      end
      chk(hall_div == exp_div, "R2", hall_div, exp_div);
    end

    // R5/R6/R8: sweep low-run lengths across the window
    on_ref = 1'b1; idle(4);
    for (int n = LMIN - 3; n <= LMAX + 3; n++) begin
      bit acc;
      if (!exp_div) hall_cycle("R3");
      acc = (n >= LMIN) && (n <= LMAX);
      burst(n);
      if (acc) exp_div = 1'b0;
      chk(hall_div == exp_div, acc ? "R5" : "R6", hall_div, exp_div);
      chk(synced == acc, "R8", synced, acc);
      if (acc) begin
        idle(20);
        chk(synced == 1'b1, "R8", synced, 1);
        hall_cycle("R7");
        chk(hall_div == 1'b1, "R7", hall_div, 1);
      end
      on_ref = 1'b0; idle(2);
      chk(synced == 1'b0, "R8", synced, 0);
      on_ref = 1'b1; idle(2);
    end

    // R9: bursts off the reference track ignored
    on_ref = 1'b0; idle(4);
    if (!exp_div) hall_cycle("R3");
    for (int n = LMIN; n <= LMAX; n += 5) begin
      burst(n);
      chk(hall_div == exp_div, "R9", hall_div, exp_div);
      chk(synced == 1'b0, "R9", synced, 0);
    end

    chk(idx_maxw == 1, "R4", idx_maxw, 1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule